// File: doc/BRIEF.md
# Speculative Execution Log Recorder

This block sits at the retirement end of a speculative thread. It watches each retired instruction and writes a compact log made only of constant-valued records, so that a later re-execution pass can check and merge the thread's results. Four things drive the log. Each register read whose value was not produced earlier in the current block becomes an assertion of that value. A load becomes an assertion that an address holds a value. A store becomes a record of constant data going to a constant address. Register results are not written out one at a time. They are held per register, and only the last value of each register is written out when the block closes.

A block is `BLOCK_N` retired instructions. When a block closes, the held register writes are written in ascending register order, after every assertion and memory record of that block. Records go into fixed-size chunks that are taken one at a time from a free-chunk port. The last word of each chunk is kept back for a link that holds the base of the next chunk, so a thread's log can spread across chunks that are not contiguous and has no fixed length. If the free-chunk port is empty when a new chunk is needed, the recorder raises `full` and stops recording.

Each log word has five parts. The first is a 2-bit record kind. The second is a register field. The third and fourth are two operand fields, A and B. The fifth is a flag that marks link words. An instruction is offered on a valid/ready pair. The recorder writes at most one log word per cycle, so it holds ready low while it works through an instruction or a block flush.

Top module: `spec_log_rec`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `full` is 0, `log_we` is 0 and `free_take` is 0.
- R2: When a source operand is enabled and names a register that was neither read nor written earlier in the current block, the recorder writes one record of kind 0 (register assertion). Its register field holds the source index, operand A holds the source value and operand B is 0. Source 1 is handled before source 2.
- R3: A register gets at most one assertion per block. This includes an instruction whose two sources name the same register, and any read of a register that was written earlier in the block.
- R4: An instruction with op code 1 (load) writes one record of kind 2. The register field is 0, operand A holds `in_addr` and operand B holds `in_result`. The record comes after that instruction's source assertions.
- R5: An instruction with op code 2 (store) writes one record of kind 3. The register field is 0, operand A holds `in_addr` and operand B holds `in_sdata`. Op code 0 (register operation) writes no memory record.
- R6: A destination write produces no record when it retires. After every `BLOCK_N`-th accepted instruction, the recorder writes one kind-1 record for each register written in that block. Operand A holds the last value written to that register and operand B is 0. These records come in ascending register order, after all other records of the block. A block with no writes adds nothing.
- R7: Records are written in the order given by R2 to R6, at consecutive word addresses from the base of the current chunk. A chunk holds at most `CHUNK_WORDS-1` records.
- R8: When a record is due and no chunk is held, or the next free word is the last word of the chunk, the recorder takes `free_base` with a one-cycle `free_take`. If a chunk is held, it also writes a link word into that last word in the same cycle. The link word has `log_link`=1 and kind 0. Its register field is 0, operand A holds the new base zero-extended, and operand B is 0.
- R9: If `free_valid` is 0 at the moment R8 needs a chunk, `full` rises and stays high until reset. From then on there are no more log writes and `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Retired instruction offered |
| in_ready | output | 1 | Instruction accepted on this edge when in_valid is high |
| in_op | input | 2 | 0 register op, 1 load, 2 store |
| in_src1_en | input | 1 | Source 1 is read |
| in_src1 | input | $clog2(NREGS) | Source 1 register index |
| in_src1_val | input | DATA_W | Value read from source 1 |
| in_src2_en | input | 1 | Source 2 is read |
| in_src2 | input | $clog2(NREGS) | Source 2 register index |
| in_src2_val | input | DATA_W | Value read from source 2 |
| in_dst_en | input | 1 | Destination register is written |
| in_dst | input | $clog2(NREGS) | Destination register index |
| in_result | input | DATA_W | Result written (load data for loads) |
| in_addr | input | DATA_W | Memory address of a load or store |
| in_sdata | input | DATA_W | Store data |
| free_valid | input | 1 | A free chunk base is offered |
| free_base | input | ADDR_W | Word address of the offered chunk |
| free_take | output | 1 | Offered chunk taken this cycle |
| log_we | output | 1 | Log word written this cycle |
| log_addr | output | ADDR_W | Word address of the log word |
| log_link | output | 1 | Word is a chunk link |
| log_kind | output | 2 | Record kind |
| log_reg | output | $clog2(NREGS) | Register field |
| log_opa | output | DATA_W | Operand A |
| log_opb | output | DATA_W | Operand B |
| full | output | 1 | No chunk was available; recording stopped |

## Verification
A corrupted seen-register mask or held-value array in this recorder surfaces at the ports. It shows up as a missing, duplicated or wrong-valued assertion record on the next read of that register. A bad held value shows up in the write records at the close of the block, at most `BLOCK_N` instructions later. A wrong chunk offset or base shows up on the very next write, as an address off the expected sequence or a link word in the wrong place. Errors in the full logic show up on the first chunk request that finds the free port empty.

// File: rtl/spec_log_rec.sv
module spec_log_rec #(
  parameter int NREGS       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 20,
  parameter int CHUNK_WORDS = 256,
  parameter int BLOCK_N     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_op,
  input  logic                       in_src1_en,
  input  logic [$clog2(NREGS)-1:0]   in_src1,
  input  logic [DATA_W-1:0]          in_src1_val,
  input  logic                       in_src2_en,
  input  logic [$clog2(NREGS)-1:0]   in_src2,
  input  logic [DATA_W-1:0]          in_src2_val,
  input  logic                       in_dst_en,
  input  logic [$clog2(NREGS)-1:0]   in_dst,
  input  logic [DATA_W-1:0]          in_result,
  input  logic [DATA_W-1:0]          in_addr,
  input  logic [DATA_W-1:0]          in_sdata,
  input  logic                       free_valid,
  input  logic [ADDR_W-1:0]          free_base,
  output logic                       free_take,
  output logic                       log_we,
  output logic [ADDR_W-1:0]          log_addr,
  output logic                       log_link,
  output logic [1:0]                 log_kind,
  output logic [$clog2(NREGS)-1:0]   log_reg,
  output logic [DATA_W-1:0]          log_opa,
  output logic [DATA_W-1:0]          log_opb,
  output logic                       full
);
  localparam int RW = $clog2(NREGS);
  localparam int CW = $clog2(CHUNK_WORDS);
  localparam int BW = $clog2(BLOCK_N + 1);
  localparam logic [CW-1:0] OFF_LAST  = CW'(CHUNK_WORDS - 1);
  localparam logic [BW-1:0] BLK_LAST  = BW'(BLOCK_N - 1);
  localparam logic [RW-1:0] REG_LAST  = RW'(NREGS - 1);
  localparam logic [1:0] K_AREG = 2'd0, K_WREG = 2'd1, K_ALOAD = 2'd2, K_STORE = 2'd3;
  localparam logic [1:0] OP_LOAD = 2'd1, OP_STORE = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SRC1, S_SRC2, S_MEM, S_FLUSH} st_t;
  st_t st;

  logic [1:0]        op_q;
  logic              s1en_q, s2en_q, den_q;
  logic [RW-1:0]     s1_q, s2_q, d_q, scan;
  logic [DATA_W-1:0] v1_q, v2_q, res_q, addr_q, sd_q;
  logic [NREGS-1:0]  known, dirty;
  logic [DATA_W-1:0] rval [NREGS];
  logic [BW-1:0]     blk_cnt;
  logic [ADDR_W-1:0] base_q;
  logic [CW-1:0]     off_q;
  logic              have_q, full_q;

  logic              need;
  logic [1:0]        kind_c;
  logic [RW-1:0]     reg_c;
  logic [DATA_W-1:0] opa_c, opb_c;

  always_comb begin
    need   = 1'b0;
    kind_c = K_AREG;
    reg_c  = '0;
    opa_c  = '0;
    opb_c  = '0;
    case (st)
      S_SRC1: begin
        need  = s1en_q && !known[s1_q];
        reg_c = s1_q;
        opa_c = v1_q;
      end
      S_SRC2: begin
        need  = s2en_q && !known[s2_q];
        reg_c = s2_q;
        opa_c = v2_q;
      end
      S_MEM: begin
        need   = (op_q == OP_LOAD) || (op_q == OP_STORE);
        kind_c = (op_q == OP_LOAD) ? K_ALOAD : K_STORE;
        opa_c  = addr_q;
        opb_c  = (op_q == OP_LOAD) ? res_q : sd_q;
      end
      S_FLUSH: begin
        need   = dirty[scan];
        kind_c = K_WREG;
        reg_c  = scan;
        opa_c  = rval[scan];
      end
      default: ;
    endcase
  end

  wire room  = have_q && (off_q != OFF_LAST);
  wire emit  = need && room && !full_q;
  wire grab  = need && !room && !full_q && free_valid;
  wire stuck = need && !room && !full_q && !free_valid;
  wire adv   = !need || emit;

  assign in_ready  = (st == S_IDLE) || full_q;
  assign full      = full_q;
  assign free_take = grab;
  assign log_link  = grab && have_q;
  assign log_we    = emit || log_link;
  assign log_addr  = base_q + ADDR_W'(off_q);
  assign log_kind  = log_link ? K_AREG : kind_c;
  assign log_reg   = log_link ? '0 : reg_c;
  assign log_opa   = log_link ? DATA_W'(free_base) : opa_c;
  assign log_opb   = log_link ? '0 : opb_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      known   <= '0;
      dirty   <= '0;
      blk_cnt <= '0;
      scan    <= '0;
      base_q  <= '0;
      off_q   <= '0;
      have_q  <= 1'b0;
      full_q  <= 1'b0;
      op_q    <= '0;
      s1en_q  <= 1'b0;
      s2en_q  <= 1'b0;
      den_q   <= 1'b0;
      s1_q    <= '0;
      s2_q    <= '0;
      d_q     <= '0;
      v1_q    <= '0;
      v2_q    <= '0;
      res_q   <= '0;
      addr_q  <= '0;
      sd_q    <= '0;
    end else if (!full_q) begin
      if (stuck) begin
        full_q <= 1'b1;
        st     <= S_IDLE;
      end else begin
        if (grab) begin
          base_q <= free_base;
          off_q  <= '0;
          have_q <= 1'b1;
        end
        if (emit) off_q <= off_q + 1'b1;
        case (st)
          S_IDLE: if (in_valid) begin
            op_q   <= in_op;
            s1en_q <= in_src1_en;
            s1_q   <= in_src1;
            v1_q   <= in_src1_val;
            s2en_q <= in_src2_en;
            s2_q   <= in_src2;
            v2_q   <= in_src2_val;
            den_q  <= in_dst_en;
            d_q    <= in_dst;
            res_q  <= in_result;
            addr_q <= in_addr;
            sd_q   <= in_sdata;
            st     <= S_SRC1;
          end
          S_SRC1: if (adv) begin
            if (need) known[s1_q] <= 1'b1;
            st <= S_SRC2;
          end
          S_SRC2: if (adv) begin
            if (need) known[s2_q] <= 1'b1;
            st <= S_MEM;
          end
          S_MEM: if (adv) begin
            if (den_q) begin
              dirty[d_q] <= 1'b1;
              known[d_q] <= 1'b1;
            end
            if (blk_cnt == BLK_LAST) begin
              blk_cnt <= '0;
              scan    <= '0;
              st      <= S_FLUSH;
            end else begin
              blk_cnt <= blk_cnt + 1'b1;
              st      <= S_IDLE;
            end
          end
          S_FLUSH: if (adv) begin
            dirty[scan] <= 1'b0;
            if (scan == REG_LAST) begin
              known <= '0;
              st    <= S_IDLE;
            end else begin
              scan <= scan + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_MEM && adv && den_q && !full_q && !stuck) rval[d_q] <= res_q;
  end
endmodule

// File: rtl/spec_log_rec_chk.sv
module spec_log_rec_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              free_valid,
  input logic              free_take,
  input logic              log_we,
  input logic              log_link,
  input logic [1:0]        log_kind,
  input logic [ADDR_W-1:0] log_addr,
  input logic [DATA_W-1:0] log_opa,
  input logic [DATA_W-1:0] log_opb,
  input logic              full
);
  logic [ADDR_W-1:0] nxt;
  logic              nxt_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt   <= '0;
      nxt_v <= 1'b0;
    end else if (log_we) begin
      nxt   <= log_link ? log_opa[ADDR_W-1:0] : log_addr + 1'b1;
      nxt_v <= 1'b1;
    end
  end

  AST_FULL_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) full |=> full); // R9
  AST_FULL_SILENT:  assert property (@(posedge clk) disable iff (!rst_n) full |-> !log_we && !free_take); // R9
  AST_FULL_READY:   assert property (@(posedge clk) disable iff (!rst_n) full |-> in_ready); // R9
  AST_TAKE_OFFER:   assert property (@(posedge clk) disable iff (!rst_n) free_take |-> free_valid); // R8
  AST_LINK_SHAPE:   assert property (@(posedge clk) disable iff (!rst_n) log_link |-> log_we && free_take && log_kind == 2'd0 && log_opb == '0); // R8
  AST_ADDR_CHAIN:   assert property (@(posedge clk) disable iff (!rst_n) (log_we && nxt_v) |-> log_addr == nxt); // R7
endmodule

bind spec_log_rec spec_log_rec_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .free_valid(free_valid),
  .free_take(free_take), .log_we(log_we), .log_link(log_link), .log_kind(log_kind),
  .log_addr(log_addr), .log_opa(log_opa), .log_opb(log_opb), .full(full)
);

// File: tb/tb_spec_log_rec.sv
`timescale 1ns/1ps
module tb_spec_log_rec;
  localparam int NR = 8, DW = 32, AW = 16, CWD = 8, BN = 4, FREE_N = 24;

  typedef struct packed {
    logic [AW-1:0] a;
    logic          l;
    logic [1:0]    k;
    logic [2:0]    r;
    logic [DW-1:0] x;
    logic [DW-1:0] y;
  } rec_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [1:0] in_op = 0;
  logic in_src1_en = 0, in_src2_en = 0, in_dst_en = 0;
  logic [2:0] in_src1 = 0, in_src2 = 0, in_dst = 0;
  logic [DW-1:0] in_src1_val = 0, in_src2_val = 0, in_result = 0, in_addr = 0, in_sdata = 0;
  logic free_valid, free_take, log_we, log_link, full;
  logic [AW-1:0] free_base, log_addr;
  logic [1:0] log_kind;
  logic [2:0] log_reg;
  logic [DW-1:0] log_opa, log_opb;

  int checks = 0, fails = 0, fidx = 0;
  rec_t expq[$];
  logic known_m [NR], dirty_m [NR];
  logic [DW-1:0] val_m [NR];
  int blk_m = 0, off_m = 0, mfree = 0;
  logic has_m = 0, full_m = 0;
  logic [AW-1:0] base_m = 0;

  always #2.5 clk = ~clk;

  spec_log_rec #(.NREGS(NR), .DATA_W(DW), .ADDR_W(AW), .CHUNK_WORDS(CWD), .BLOCK_N(BN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src1_en(in_src1_en), .in_src1(in_src1), .in_src1_val(in_src1_val),
    .in_src2_en(in_src2_en), .in_src2(in_src2), .in_src2_val(in_src2_val),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_result(in_result), .in_addr(in_addr),
    .in_sdata(in_sdata), .free_valid(free_valid), .free_base(free_base), .free_take(free_take),
    .log_we(log_we), .log_addr(log_addr), .log_link(log_link), .log_kind(log_kind),
    .log_reg(log_reg), .log_opa(log_opa), .log_opb(log_opb), .full(full));

  function automatic logic [AW-1:0] fbase(int i);
    return AW'(200 + i * 29);
  endfunction

  assign free_valid = (fidx < FREE_N);
  assign free_base  = fbase(fidx);
  always @(posedge clk) if (!rst_n) fidx <= 0; else if (free_take) fidx <= fidx + 1;

  function automatic string tag_of(rec_t e);
    if (e.l) return "R8";
    case (e.k)
      2'd0: return "R2";
      2'd1: return "R6";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic ok, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && log_we) begin
      rec_t got, e;
      got = {log_addr, log_link, log_kind, log_reg, log_opa, log_opb};
      if (expq.size() == 0) begin
        check("R9", 1'b0, "unexpected log write", 128'(got), 128'(0));
      end else begin
        e = expq.pop_front();
        if (got.a != e.a) check("R7", 1'b0, "log address", 128'(got.a), 128'(e.a));
        else check(tag_of(e), got == e, "log word", 128'(got), 128'(e));
      end
    end
  end

  task automatic push_rec(logic [1:0] k, logic [2:0] r, logic [DW-1:0] x, logic [DW-1:0] y);
    logic [AW-1:0] nb;
    if (full_m) return;
    if (!has_m || off_m == CWD - 1) begin
      if (mfree < FREE_N) begin
        nb = fbase(mfree);
        if (has_m) expq.push_back({base_m + AW'(off_m), 1'b1, 2'd0, 3'd0, DW'(nb), {DW{1'b0}}});
        base_m = nb; off_m = 0; has_m = 1; mfree++;
      end else begin
        full_m = 1;
        return;
      end
    end
    expq.push_back({base_m + AW'(off_m), 1'b0, k, r, x, y});
    off_m++;
  endtask

  task automatic issue(logic [1:0] op, logic e1, logic [2:0] s1, logic [DW-1:0] v1,
                       logic e2, logic [2:0] s2, logic [DW-1:0] v2,
                       logic ed, logic [2:0] d, logic [DW-1:0] res,
                       logic [DW-1:0] addr, logic [DW-1:0] sd);
    if (e1 && !known_m[s1]) begin push_rec(2'd0, s1, v1, '0); known_m[s1] = 1; end
    if (e2 && !known_m[s2]) begin push_rec(2'd0, s2, v2, '0); known_m[s2] = 1; end
    if (op == 2'd1) push_rec(2'd2, 3'd0, addr, res);
    if (op == 2'd2) push_rec(2'd3, 3'd0, addr, sd);
    if (ed) begin val_m[d] = res; dirty_m[d] = 1; known_m[d] = 1; end
    blk_m++;
    if (blk_m == BN) begin
      blk_m = 0;
      for (int r = 0; r < NR; r++) begin
        if (dirty_m[r]) push_rec(2'd1, 3'(r), val_m[r], '0);
        dirty_m[r] = 0; known_m[r] = 0;
      end
    end
    in_op = op; in_src1_en = e1; in_src1 = s1; in_src1_val = v1;
    in_src2_en = e2; in_src2 = s2; in_src2_val = v2;
    in_dst_en = ed; in_dst = d; in_result = res; in_addr = addr; in_sdata = sd;
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int r = 0; r < NR; r++) begin known_m[r] = 0; dirty_m[r] = 0; val_m[r] = 0; end
    repeat (3) @(negedge clk);
    check("R1", in_ready == 1'b1, "ready in reset", 128'(in_ready), 128'(1));
    check("R1", log_we == 1'b0 && free_take == 1'b0, "writes in reset", 128'({log_we, free_take}), 128'(0));
    check("R1", full == 1'b0, "full in reset", 128'(full), 128'(0));
    rst_n = 1;
    @(negedge clk);
    check("R1", in_ready == 1'b1 && full == 1'b0 && log_we == 1'b0, "after reset", 128'({in_ready, full, log_we}), 128'(4));

    // R2 R6: four increments of r1 collapse to one assertion and one write
    for (int i = 0; i < 4; i++)
      issue(2'd0, 1, 3'd1, DW'(i), 0, 0, 0, 1, 3'd1, DW'(i + 1), 0, 0);
    // R3 R4 R5: load, store with known source, same register twice, read of written reg
    issue(2'd1, 1, 3'd1, 32'd4, 0, 0, 0, 1, 3'd2, 32'd66, 32'd4, 0);
    issue(2'd2, 1, 3'd4, 32'd55, 1, 3'd2, 32'd66, 0, 0, 0, 32'd55, 32'd66);
    issue(2'd0, 1, 3'd5, 32'd9, 1, 3'd5, 32'd9, 1, 3'd6, 32'd18, 0, 0);
    issue(2'd0, 1, 3'd6, 32'd18, 1, 3'd2, 32'd66, 1, 3'd6, 32'd84, 0, 0);
    // R6: block with no writes emits no write records
    for (int i = 0; i < 4; i++)
      issue(2'd2, 1, 3'd7, 32'h100, 0, 0, 0, 0, 0, 0, DW'(32'h100 + i), DW'(i));

    for (int n = 0; n < 260; n++) begin
      issue(2'($urandom % 3), 1'($urandom), 3'($urandom), $urandom,
            1'($urandom), 3'($urandom), $urandom,
            1'($urandom), 3'($urandom), $urandom, $urandom, $urandom);
    end
    repeat (120) @(negedge clk);
    check("R7", expq.size() == 0, "records left unwritten", 128'(expq.size()), 128'(0));
    check("R9", full == full_m, "full flag", 128'(full), 128'(full_m));
    check("R9", full_m == 1'b1, "free list exhausted by stimulus", 128'(full_m), 128'(1));
    check("R9", in_ready == 1'b1 && log_we == 1'b0, "ready and silent when full", 128'({in_ready, log_we}), 128'(2));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule